// File: doc/BRIEF.md
# Shared interrupt affinity router table

This block holds one routing register per shared interrupt. Software writes a target affinity into a register over a simple register bus. The block compares that affinity with a parameterised list of CPU affinities. If one CPU matches, the block records that CPU's index and sets the interrupt's bit in that CPU's target bitmap. If no CPU matches, the interrupt is left with no target: it can still become pending elsewhere, but it is never delivered.

The affinity is kept in compressed form as four bytes. Affinity level 0 is in bits [7:0], level 1 in [15:8], level 2 in [23:16] and level 3 in [31:24]. Each register reads back exactly as written. The outputs are, for every interrupt, an 8-bit target index and a valid flag, and for every CPU a bitmap over the shared interrupts. A downstream delivery stage uses these outputs; prioritisation and delivery are outside this block.

Top module: `spi_aff_router`

## Requirements
- R1: After reset, every entry has target index 0 and valid set, and reads back CPU 0's affinity. CPU 0's bitmap has all bits set and every other CPU's bitmap is zero.
- R2: Entry n is a 64-bit register at byte offset 0x100 + 8n, that is, just past the slots of the first 32 interrupt IDs. Its low 32-bit word is the one with address bit 2 clear. Address bits [1:0] are not decoded.
- R3: A read returns on `rdata_o` exactly the 32-bit value last written to that low word, one clock after the read request.
- R4: A read of the upper word (address bit 2 set) returns zero, and a write to it leaves every output unchanged.
- R5: After a low-word write whose value equals CPU k's affinity, the next cycle shows target index k, valid 1, and the entry's bit set in CPU k's bitmap.
- R6: A rewrite moves the entry's bit: it is cleared in the previously matched CPU's bitmap. Each entry's bit is set in at most one CPU's bitmap.
- R7: After a write whose value matches no CPU, the next cycle shows target index 0xFF (the not-allocated code), valid 0, and the entry's bit clear in every bitmap.
- R8: An address below 0x100, or at or beyond 0x100 + 8*NUM_SPI, reads zero and its write leaves every output unchanged.
- R9: Matching compares all four affinity bytes. A value that differs from a CPU's affinity only in the level 3 byte does not match that CPU.
- R10: Routing outputs change only in the cycle after an in-window low-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| tgt_idx_o | output | NUM_SPI*8 | Target CPU index per entry; 0xFF means no target |
| tgt_vld_o | output | NUM_SPI | Entry has a matched target CPU |
| cpu_map_o | output | NUM_CPU*NUM_SPI | Per-CPU bitmap of the entries routed to that CPU |

## Verification
A write is sampled on the rising edge where `req_i` and `we_i` are both high. The new index, valid flag and bitmap bits are visible after that same edge, so they are due in the following cycle. Read data comes from a register and is due one cycle after the read request. The bench drives every access on the falling edge and checks the results on the next falling edge, where both kinds of result have settled. Each write is followed by a check of every entry's index and valid flag and every CPU's bitmap against a model kept in the bench. This also covers entries that the write should not have touched.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned AFF_W = 32;
  typedef logic [IDX_W-1:0] cpu_idx_t;
  typedef logic [AFF_W-1:0] aff_t;
  localparam cpu_idx_t IDX_NONE = 8'hFF;
  // window starts after the slots of the first 32 interrupt IDs
  localparam int unsigned WIN_BASE = 32 * 8;
endpackage

// File: rtl/spi_route_match.sv
module spi_route_match
  import spi_route_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter logic [NUM_CPU-1:0][AFF_W-1:0] CPU_AFF = '0
) (
  input  aff_t     aff_i,
  output cpu_idx_t idx_o,
  output logic     hit_o
);
  // lowest CPU index wins on duplicate affinities
  always_comb begin
    hit_o = 1'b0;
    idx_o = IDX_NONE;
    for (int k = NUM_CPU - 1; k >= 0; k--) begin
      if (aff_i == CPU_AFF[k]) begin
        hit_o = 1'b1;
        idx_o = cpu_idx_t'(k);
      end
    end
  end
endmodule

// File: rtl/spi_route_entry.sv
module spi_route_entry
  import spi_route_pkg::*;
#(
  parameter aff_t RST_AFF = '0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  aff_t     aff_i,
  input  cpu_idx_t idx_i,
  output aff_t     aff_o,
  output cpu_idx_t idx_o,
  output logic     vld_o
);
  aff_t     aff_q;
  cpu_idx_t idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aff_q <= RST_AFF;
      idx_q <= '0;
    end else if (wr_i) begin
      aff_q <= aff_i;
      idx_q <= idx_i;
    end
  end

  assign aff_o = aff_q;
  assign idx_o = idx_q;
  assign vld_o = (idx_q != IDX_NONE);
endmodule

// File: rtl/spi_route_cpu_map.sv
module spi_route_cpu_map
  import spi_route_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SPI = 32,
  localparam int unsigned SEL_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  cpu_idx_t                        old_idx_i,
  input  cpu_idx_t                        new_idx_i,
  input  logic                            new_hit_i,
  output logic [NUM_CPU-1:0][NUM_SPI-1:0] map_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SPI-1:0] map_q;
    logic [NUM_SPI-1:0] map_d;

    always_comb begin
      map_d = map_q;
      if (wr_i) begin
        // clear in the previous owner first, then set in the new one
        if (old_idx_i == cpu_idx_t'(c)) map_d[sel_i] = 1'b0;
        if (new_hit_i && new_idx_i == cpu_idx_t'(c)) map_d[sel_i] = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_q <= (c == 0) ? '1 : '0;
      else         map_q <= map_d;
    end

    assign map_o[c] = map_q;
  end
endmodule

// File: rtl/spi_aff_router.sv
module spi_aff_router
  import spi_route_pkg::*;
#(
  parameter int unsigned NUM_SPI = 32,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 16,
  parameter logic [NUM_CPU-1:0][AFF_W-1:0] CPU_AFF =
    {32'h0000_0103, 32'h0000_0102, 32'h0000_0101, 32'h0000_0100}
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  output logic [NUM_SPI-1:0][7:0]         tgt_idx_o,
  output logic [NUM_SPI-1:0]              tgt_vld_o,
  output logic [NUM_CPU-1:0][NUM_SPI-1:0] cpu_map_o
);
  localparam int unsigned SEL_W     = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam int unsigned WIN_BYTES = 8 * NUM_SPI;

  // one code is reserved for "no target"; the offset math needs room for the index
  if (NUM_CPU > 255 || NUM_CPU < 1) begin : g_bad_cpu
    $error("NUM_CPU must be 1..255");
  end
  if (SEL_W + 3 > ADDR_W) begin : g_bad_addr
    $error("ADDR_W too small for NUM_SPI");
  end

  // extra top bit so an address below the window wraps to a large offset
  logic [ADDR_W:0]  off;
  logic             in_win;
  logic             lo_word;
  logic [SEL_W-1:0] sel;
  logic             wr_hit;

  assign off     = {1'b0, addr_i} - (ADDR_W+1)'(WIN_BASE);
  assign in_win  = off < (ADDR_W+1)'(WIN_BYTES);
  assign lo_word = ~off[2];
  assign sel     = off[SEL_W+2:3];
  assign wr_hit  = req_i && we_i && in_win && lo_word;

  // a single matcher serves the one write per cycle
  cpu_idx_t new_idx;
  logic     new_hit;

  spi_route_match #(.NUM_CPU(NUM_CPU), .CPU_AFF(CPU_AFF)) u_match (
    .aff_i (wdata_i),
    .idx_o (new_idx),
    .hit_o (new_hit)
  );

  aff_t     aff_arr [NUM_SPI];
  cpu_idx_t idx_arr [NUM_SPI];

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_ent
    logic ent_wr;
    assign ent_wr = wr_hit && (sel == SEL_W'(s));

    spi_route_entry #(.RST_AFF(CPU_AFF[0])) u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ent_wr),
      .aff_i  (wdata_i),
      .idx_i  (new_idx),
      .aff_o  (aff_arr[s]),
      .idx_o  (idx_arr[s]),
      .vld_o  (tgt_vld_o[s])
    );

    assign tgt_idx_o[s] = idx_arr[s];
  end

  spi_route_cpu_map #(.NUM_CPU(NUM_CPU), .NUM_SPI(NUM_SPI)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_hit),
    .sel_i     (sel),
    .old_idx_i (idx_arr[sel]),
    .new_idx_i (new_idx),
    .new_hit_i (new_hit),
    .map_o     (cpu_map_o)
  );

  logic [31:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  rdata_q <= '0;
    else if (req_i && !we_i && in_win && lo_word) rdata_q <= aff_arr[sel];
    else                                          rdata_q <= '0;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/spi_aff_router_chk.sv
module spi_aff_router_chk #(
  parameter int unsigned NUM_SPI = 32,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            req_i,
  input logic                            we_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [31:0]                     rdata_o,
  input logic [NUM_SPI-1:0][7:0]         tgt_idx_o,
  input logic [NUM_SPI-1:0]              tgt_vld_o,
  input logic [NUM_CPU-1:0][NUM_SPI-1:0] cpu_map_o
);
  localparam int unsigned LO = 256;
  localparam int unsigned HI = 256 + 8 * NUM_SPI;

  logic oob;
  logic win_wr;
  assign oob    = (int'(addr_i) < LO) || (int'(addr_i) >= HI);
  assign win_wr = req_i && we_i && !oob && !addr_i[2];

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_col
    logic [NUM_CPU-1:0] col;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bit
      assign col[c] = cpu_map_o[c][s];
    end

    assert_map_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col) <= 1);
    assert_map_tgt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_vld_o[s] |-> (int'(tgt_idx_o[s]) < NUM_CPU) && col[tgt_idx_o[s]]);
    assert_no_map_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tgt_vld_o[s] |-> (col == '0));
  end

  assert_hi_raz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[2]) |=> (rdata_o == 32'h0));
  assert_oob_raz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && oob) |=> (rdata_o == 32'h0));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_wr |=> ($stable(tgt_idx_o) && $stable(cpu_map_o) && $stable(tgt_vld_o)));
endmodule

bind spi_aff_router spi_aff_router_chk #(
  .NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .tgt_idx_o (tgt_idx_o),
  .tgt_vld_o (tgt_vld_o),
  .cpu_map_o (cpu_map_o)
);

// File: tb/spi_aff_router_test.sv
module spi_aff_router_test;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int AW = 16;
  localparam int BASE = 256;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req = 1'b0;
  logic                 we = 1'b0;
  logic [AW-1:0]        addr = '0;
  logic [31:0]          wdata = '0;
  logic [31:0]          rdata;
  logic [NS-1:0][7:0]   tidx;
  logic [NS-1:0]        tvld;
  logic [NC-1:0][NS-1:0] cmap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_aff [NS];

  always #5 clk = ~clk;

  spi_aff_router #(.NUM_SPI(NS), .NUM_CPU(NC), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tgt_idx_o(tidx), .tgt_vld_o(tvld),
    .cpu_map_o(cmap)
  );

  // CPU k has affinity level1=1, level0=k
  function automatic logic [7:0] exp_idx(logic [31:0] a);
    for (int k = 0; k < NC; k++) if (a == 32'h100 + k) return 8'(k);
    return 8'hFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    for (int s = 0; s < NS; s++) begin
      logic [7:0] ei;
      ei = exp_idx(m_aff[s]);
      chk($sformatf("%s idx[%0d]", tag, s), 32'(tidx[s]), 32'(ei));
      chk($sformatf("%s vld[%0d]", tag, s), 32'(tvld[s]), 32'(ei != 8'hFF));
      for (int c = 0; c < NC; c++)
        chk($sformatf("%s map[%0d][%0d]", tag, c, s), 32'(cmap[c][s]),
            32'(ei == 8'(c)));
    end
  endtask

  // drive on falling edge, result due by next falling edge
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) m_aff[s] = 32'h100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");
    for (int s = 0; s < NS; s++) rd(BASE + 8*s, 32'h100, "R1 reset readback");

    // R5/R6: every entry through every CPU, ending back on CPU 0
    for (int s = 0; s < NS; s++) begin
      for (int j = 1; j <= NC; j++) begin
        int k;
        k = j % NC;
        wr(BASE + 8*s, 32'h100 + k);
        m_aff[s] = 32'h100 + k;
        chk_all("R5 R6 move");
        rd(BASE + 8*s, 32'h100 + k, "R3 readback");
      end
    end

    // R2: address bits [1:0] not decoded
    for (int s = 0; s < NS; s++) begin
      wr(BASE + 8*s + (s % 4), 32'h100 + ((s + 1) % NC));
      m_aff[s] = 32'h100 + ((s + 1) % NC);
    end
    chk_all("R2 spread");
    for (int s = 0; s < NS; s++) rd(BASE + 8*s + 3, m_aff[s], "R2 R3 readback");

    // R7: unmatched values, including one just past the last CPU
    wr(BASE + 8*2, 32'h104);          m_aff[2] = 32'h104;
    chk_all("R7 unmatched");
    wr(BASE + 8*5, 32'h5A5A_5A5A);    m_aff[5] = 32'h5A5A_5A5A;
    chk_all("R7 unmatched");
    rd(BASE + 8*5, 32'h5A5A_5A5A, "R3 unmatched readback");
    // R9: differs from CPU 1 only in the level 3 byte
    wr(BASE + 8*7, 32'h0100_0101);    m_aff[7] = 32'h0100_0101;
    chk_all("R9 level3");
    rd(BASE + 8*7, 32'h0100_0101, "R9 readback");
    // unmatched back to matched
    wr(BASE + 8*2, 32'h103);          m_aff[2] = 32'h103;
    chk_all("R6 from none");

    // R4: upper word
    for (int s = 0; s < NS; s++) begin
      wr(BASE + 8*s + 4, 32'h102);
      chk_all("R4 upper write");
      rd(BASE + 8*s + 4, 32'h0, "R4 upper read");
    end

    // R8: outside the window
    wr(BASE - 8, 32'h101);   chk_all("R8 below");
    wr(BASE - 1, 32'h101);   chk_all("R8 below");
    wr(BASE + 8*NS, 32'h101); chk_all("R8 above");
    wr(0, 32'h102);          chk_all("R8 zero");
    rd(BASE - 8, 32'h0, "R8 below read");
    rd(BASE + 8*NS, 32'h0, "R8 above read");
    rd(0, 32'h0, "R8 zero read");
    rd(BASE + 8*(NS - 1), m_aff[NS-1], "R2 last entry");

    // R10: idle cycles leave state alone
    repeat (5) @(negedge clk);
    chk_all("R10 idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule